// File: doc/BRIEF.md
# Watchdog Timer with Prescaler and Early Warning

This block watches over system software. Once enabled, it counts prescaled clock ticks up to a selected interval. Software keeps it quiet by writing the restart bit before the interval runs out. If the interval runs out, the block sets an interrupt flag, which can drive a warning interrupt. If the watchdog is still not restarted, the block asserts a reset request a fixed number of prescaled ticks later, provided that reset is allowed.

The block is controlled through one 32-bit register on a single-cycle port. Writes take effect at the clock edge where `wr_en` is high. Reads are combinational.

The total timeout is the product of two settings:
- A 2-bit prescaler field gives the clock divide. Its steps are not uniform: 1, `BASE_DIV`, 8·`BASE_DIV` and 256·`BASE_DIV`.
- A 2-bit interval field gives the tick count: `N_TICKS` multiplied by 1, 4, 16 or 64.

The reset flag sits in a separate reset domain (`por_n`). It therefore survives the system reset (`rst_n`) that the watchdog itself requests, and software can read the reset cause afterwards.

Top module: `wdog_timer`

## Requirements
- R1: After `por_n` and `rst_n` are released, `rd_data` reads 0 and both `wd_irq` and `wd_reset` are low.
- R2: The register fields are:
  - prescaler select at bits 11:10
  - enable at bit 7
  - interrupt enable at bit 6
  - interval select at bits 5:4
  - interrupt flag at bit 3
  - reset flag at bit 2
  - reset enable at bit 1
  - restart at bit 0

  The written configuration fields read back unchanged. Bit 0 always reads 0, and so do all other bits.
- R3: A write with enable=1 and restart=1 starts the count from zero. The interrupt flag sets exactly T = (`N_TICKS`·4^interval)·P clock edges after that write edge. P is 1, `BASE_DIV`, 8·`BASE_DIV` or 256·`BASE_DIV` for prescaler 00, 01, 10 or 11.
- R4: The flag sets at expiry whatever the interrupt enable is. `wd_irq` is high only while both the flag and the interrupt enable are 1.
- R5: With reset enable set and no restart after expiry, `wd_reset` and the reset flag go high `RST_DLY`·P clock edges after the expiry edge. `wd_reset` then stays high until a restart, a disable or `rst_n`.
- R6: With reset enable clear, expiry never asserts `wd_reset` or the reset flag.
- R7: A restart write before expiry restarts the full timeout, measured from that write.
- R8: A write of all zeros stops the watchdog. No interrupt flag and no reset follow.
- R9: Writing 1 to bit 3 or bit 2 clears that flag. Writing 0 to either leaves it unchanged.
- R10: `rst_n` clears everything except the reset flag. Only `por_n` clears the reset flag.
- R11: A restart written after expiry but before the reset fires cancels the pending reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous; clears the reset flag |
| rst_n | input | 1 | System reset, active low, asynchronous; clears all other state |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write data |
| rd_data | output | 32 | Register read data |
| wd_irq | output | 1 | Early-warning interrupt |
| wd_reset | output | 1 | Reset request to the system |

## Verification
The assertions rely on two things about the inputs:
- Both resets start asserted, so no property sees the state from before reset.
- The register is changed only through `wr_en` cycles, with the enable and restart bits meant as written.

Stimulus stays inside these limits. Writes are driven on falling clock edges, one write at a time. The random prescaler and interval picks are capped, so every timeout fits the run. Restarts land only at offsets strictly inside the current window, which keeps each expected expiry edge well defined.

// File: rtl/wdog_timer.sv
module wdog_timer #(
  parameter int BASE_DIV = 4,
  parameter int N_TICKS  = 4,
  parameter int RST_DLY  = 2
) (
  input  logic        clk,
  input  logic        por_n,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  output logic        wd_irq,
  output logic        wd_reset
);
  localparam int PW = $clog2(BASE_DIV * 256 + 1);
  localparam int CW = $clog2(N_TICKS * 64 + 1);
  localparam int DW = $clog2(RST_DLY + 1);

  logic [1:0]    pre_sel, iv_sel;
  logic          en, ie, rst_en, irq_flag, rst_flag, expired;
  logic [PW-1:0] pdiv, div_len;
  logic [CW-1:0] cnt, limit;
  logic [DW-1:0] dly;
  logic          tick, expire_now, fire_now;

  wire wr_restart = wr_en & (wr_data[0] | ~wr_data[7]);

  always_comb begin
    case (pre_sel)
      2'd0:    div_len = PW'(1);
      2'd1:    div_len = PW'(BASE_DIV);
      2'd2:    div_len = PW'(BASE_DIV * 8);
      default: div_len = PW'(BASE_DIV * 256);
    endcase
  end

  assign limit      = CW'(N_TICKS) << (2 * iv_sel);
  assign tick       = en & (pdiv >= div_len - PW'(1));
  assign expire_now = tick & ~expired & (cnt >= limit - CW'(1)) & ~wr_restart;
  assign fire_now   = tick & expired & rst_en & ~wd_reset
                      & (dly >= DW'(RST_DLY - 1)) & ~wr_restart;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_sel <= '0;
      iv_sel  <= '0;
      en      <= 1'b0;
      ie      <= 1'b0;
      rst_en  <= 1'b0;
    end else if (wr_en) begin
      pre_sel <= wr_data[11:10];
      iv_sel  <= wr_data[5:4];
      en      <= wr_data[7];
      ie      <= wr_data[6];
      rst_en  <= wr_data[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pdiv     <= '0;
      cnt      <= '0;
      dly      <= '0;
      expired  <= 1'b0;
      wd_reset <= 1'b0;
      irq_flag <= 1'b0;
    end else begin
      if (wr_restart) begin
        pdiv     <= '0;
        cnt      <= '0;
        dly      <= '0;
        expired  <= 1'b0;
        wd_reset <= 1'b0;
      end else if (en) begin
        pdiv <= tick ? '0 : pdiv + PW'(1);
        if (tick && !expired)
          cnt <= expire_now ? '0 : cnt + CW'(1);
        if (expire_now)
          expired <= 1'b1;
        if (tick && expired && dly < DW'(RST_DLY - 1))
          dly <= dly + DW'(1);
        if (fire_now)
          wd_reset <= 1'b1;
      end
      if (expire_now)
        irq_flag <= 1'b1;
      else if (wr_en && wr_data[3])
        irq_flag <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)
      rst_flag <= 1'b0;
    else if (fire_now)
      rst_flag <= 1'b1;
    else if (wr_en && wr_data[2])
      rst_flag <= 1'b0;
  end

  assign rd_data = {20'd0, pre_sel, 2'd0, en, ie, iv_sel, irq_flag, rst_flag, rst_en, 1'b0};
  assign wd_irq  = irq_flag & ie;
endmodule

// File: rtl/wdog_timer_sva.sv
module wdog_timer_sva (
  input logic        clk,
  input logic        por_n,
  input logic        rst_n,
  input logic        wr_en,
  input logic [31:0] wr_data,
  input logic [31:0] rd_data,
  input logic        wd_irq,
  input logic        wd_reset
);
  p_irq_needs_ie_r4: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    wd_irq |-> rd_data[6]);

  p_reset_sets_flag_r5: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    $rose(wd_reset) |-> rd_data[2]);

  p_reset_needs_enable_r6: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    $rose(wd_reset) |-> $past(rd_data[1]));

  p_restart_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (wr_en && wr_data[0]) |=> (!wd_reset && !$rose(rd_data[3])));

  p_stopped_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    !rd_data[7] |=> (!$rose(rd_data[3]) && !$rose(wd_reset)));
endmodule

bind wdog_timer wdog_timer_sva i_sva (
  .clk(clk), .por_n(por_n), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .rd_data(rd_data), .wd_irq(wd_irq), .wd_reset(wd_reset)
);

// File: tb/test_wdog_timer.sv
module test_wdog_timer;
  localparam int BASE = 4;
  localparam int NT   = 4;
  localparam int DLY  = 2;

  logic        clk = 1'b0;
  logic        por_n = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        wd_irq, wd_reset;
  int          n_chk = 0, n_fail = 0, cycles = 0;

  wdog_timer #(.BASE_DIV(BASE), .N_TICKS(NT), .RST_DLY(DLY)) i_wdog_timer (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .wd_irq(wd_irq), .wd_reset(wd_reset));

  always #5 clk = ~clk;

  function automatic int period(input int pre);
    case (pre)
      0: return 1;
      1: return BASE;
      2: return BASE * 8;
      default: return BASE * 256;
    endcase
  endfunction

  function automatic int span(input int iv);
    return NT << (2 * iv);
  endfunction

  function automatic logic [31:0] cfg(input int pre, input int iv, input bit e,
                                      input bit ie, input bit re, input bit rs);
    return (32'(pre) << 10) | (32'(e) << 7) | (32'(ie) << 6) | (32'(iv) << 4)
           | (32'(re) << 1) | 32'(rs);
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    wr_en = 1'b1;
    wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
    wr_data = '0;
  endtask

  task automatic adv(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // After a restart write: check the expiry edge, then the reset edge or its absence
  task automatic run_window(input int pre, input int iv, input bit ie, input bit re);
    int t, d;
    t = span(iv) * period(pre);
    d = DLY * period(pre);
    adv(t - 1);
    chk("R3 flag before timeout", 32'(rd_data[3]), 0);
    adv(1);
    chk("R3 flag at timeout", 32'(rd_data[3]), 1);
    chk("R4 irq follows enable", 32'(wd_irq), 32'(ie));
    adv(d - 1);
    chk("R5 reset not early", 32'(wd_reset), 0);
    adv(1);
    if (re) begin
      chk("R5 reset output", 32'(wd_reset), 1);
      chk("R5 reset flag", 32'(rd_data[2]), 1);
    end else begin
      adv(5);
      chk("R6 no reset output", 32'(wd_reset), 0);
      chk("R6 no reset flag", 32'(rd_data[2]), 0);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 190000) begin
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
        finish_run();
      end
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd2024));
    adv(3);
    por_n = 1'b1;
    rst_n = 1'b1;
    adv(1);
    chk("R1 rd_data", rd_data, 0);
    chk("R1 irq", 32'(wd_irq), 0);
    chk("R1 reset", 32'(wd_reset), 0);

    d = cfg(1, 1, 1, 1, 1, 1);
    wr(d);
    chk("R2 readback", rd_data, d & ~32'h1);
    run_window(1, 1, 1, 1);

    // R9: flags cleared only by writing 1
    wr(cfg(1, 1, 1, 1, 1, 0));
    chk("R9 irq flag kept", 32'(rd_data[3]), 1);
    chk("R9 reset flag kept", 32'(rd_data[2]), 1);
    wr(cfg(1, 1, 1, 1, 1, 0) | 32'h8);
    chk("R9 irq flag cleared", 32'(rd_data[3]), 0);
    chk("R9 reset flag stays", 32'(rd_data[2]), 1);

    // R10: system reset keeps the reset flag
    rst_n = 1'b0;
    adv(1);
    rst_n = 1'b1;
    adv(1);
    chk("R10 flag survives rst_n", rd_data, 32'h4);
    chk("R10 reset output cleared", 32'(wd_reset), 0);
    por_n = 1'b0;
    adv(1);
    por_n = 1'b1;
    adv(1);
    chk("R10 por clears flag", rd_data, 0);

    wr(cfg(0, 0, 1, 0, 0, 1));
    run_window(0, 0, 0, 0);
    wr(32'hC);

    // R11: restart after expiry cancels the pending reset
    wr(cfg(0, 0, 1, 1, 1, 1));
    adv(span(0));
    chk("R11 expired", 32'(rd_data[3]), 1);
    wr(cfg(0, 0, 1, 1, 1, 1) | 32'h8);
    adv(2);
    chk("R11 reset cancelled", 32'(wd_reset), 0);
    chk("R11 reset flag clear", 32'(rd_data[2]), 0);
    chk("R11 irq flag clear", 32'(rd_data[3]), 0);

    // R8: writing zero stops it
    wr(cfg(0, 0, 1, 1, 1, 1));
    adv(1);
    wr(32'h0);
    adv(span(0) + DLY + 20);
    chk("R8 stopped register", rd_data, 0);
    chk("R8 stopped reset", 32'(wd_reset), 0);

    // R3: largest prescaler step
    wr(cfg(3, 0, 1, 1, 1, 1));
    run_window(3, 0, 1, 1);
    wr(32'hC);

    // Random windows with a restart inside each window (R7)
    for (int k = 0; k < 8; k++) begin
      int pre, iv, r, t;
      bit ie, re;
      pre = int'($urandom % 3);
      iv  = int'($urandom % 4);
      if (pre == 2 && iv == 3) iv = 2;
      ie = 1'($urandom);
      re = 1'($urandom);
      t  = span(iv) * period(pre);
      r  = 1 + int'($urandom % (t - 1));
      wr(cfg(pre, iv, 1, ie, re, 1));
      adv(r - 1);
      chk("R7 no flag before restart", 32'(rd_data[3]), 0);
      wr(cfg(pre, iv, 1, ie, re, 1));
      run_window(pre, iv, ie, re);
      wr(32'hC);
      chk("R8 cleared and stopped", rd_data, 0);
    end

    finish_run();
  end
endmodule